// File: doc/BRIEF.md
# Serial scan SRAM test controller

This block lets a handful of slow pins exercise a set of small on-chip memories for test. A 112-bit command frame is clocked into a shift register one bit per rising edge of the scan clock. The frame names a bank and describes one access for each of two memory ports: address, data, active-low select, active-low write enable and a byte-lane write mask. A one-cycle low pulse on the launch input then performs both port accesses on the chosen bank.

A separate capture pulse copies the words read at the last launch into the data fields of the shift register. The frame is then shifted out on the serial output, most significant bit first. Banks 0 to 4 have two ports. Banks 8 to 11 have one port and act on the port-0 fields only. All other bank codes do nothing. Behavioural memories of 2^ADDR_BITS words stand in for the real macros.

Top module: `scan_sram_tester`

## Requirements
- R1: After synchronous reset the shift register, the serial output, both read results and every memory word are zero.
- R2: On a rising edge with scan_en high and capture low, the register shifts toward its MSB and takes scan_in into bit 0. scan_out always shows bit 111, so a frame shifted in comes back out in the same bit order.
- R3: Frame bit positions: bank 111:108; port-0 address 107:92, data 91:60, select_n 59, write_n 58, mask 57:54; port-1 address 53:38, data 37:6, select_n 5, write_n 4, mask 3:0.
- R4: launch_n low at a rising edge performs one access per port of the selected bank, using the frame held before that edge. select_n=0 with write_n=0 writes. select_n=0 with write_n=1 reads. select_n=1 leaves the port idle.
- R5: Mask bit k enables data byte k (bits 8k+7:8k) on a write. A mask of zero leaves the word unchanged.
- R6: capture high at a rising edge loads the port-0 result into bits 91:60 and the port-1 result into bits 37:6, and keeps all other bits. Capture wins over a shift requested at the same edge.
- R7: Each port result is the word that port read at the most recent launch. A port that wrote or idled at that launch yields zero.
- R8: Bank codes 0-4 select dual-port banks and 8-11 select single-port banks. A single-port bank ignores the port-1 fields and its port-1 result is zero. Each bank keeps its own contents.
- R9: Bank codes 5-7 and 12-15 perform no access, and both results are zero.
- R10: Without a launch pulse no memory changes, however the register is shifted.
- R11: A read sees the contents from before its launch edge, even when the other port writes that address at the same edge. When both ports write the same byte, port 1 wins.
- R12: A port whose address has any bit set at or above ADDR_BITS performs no access, and its result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Shift enable |
| scan_in | input | 1 | Serial frame input |
| launch_n | input | 1 | Active-low access strobe |
| capture | input | 1 | Loads read results into the frame |
| scan_out | output | 1 | Serial frame output (register MSB) |

## Verification
Every dual-port bank is written through both ports at distinct addresses and read back through both ports, and every single-port bank is written and read through port 0. These runs separate correct bank steering and field decode from crossed ports or crossed banks. Mixed and zero masks on a word with distinct bytes expose a wrong lane order. Same-edge read/write and write/write pairs on one address pin down the ordering rules. Unmapped bank codes, out-of-range addresses, select-high frames and frames shifted in without a launch must all leave earlier contents intact. A plain shift-through without capture, and a capture with shift also requested, separate the serial path from the capture path.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int FRAME_W = 112;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int MASK_W  = DATA_W / 8;
    localparam int SEL_W   = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              sel_n;
        logic              wr_n;
        logic [MASK_W-1:0] mask;
    } port_cmd_t;

    typedef struct packed {
        logic [SEL_W-1:0] bank;
        port_cmd_t        p0;
        port_cmd_t        p1;
    } frame_t;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_DUAL   = 2'd1,
        KIND_SINGLE = 2'd2
    } bank_kind_t;

    function automatic bank_kind_t classify(input logic [SEL_W-1:0] code,
                                            input int n_dual,
                                            input int single_base,
                                            input int n_single);
        int v;
        v = int'(code);
        if (v < n_dual)
            return KIND_DUAL;
        if (v >= single_base && v < single_base + n_single)
            return KIND_SINGLE;
        return KIND_NONE;
    endfunction

    function automatic logic wants_write(input port_cmd_t p);
        return !p.sel_n && !p.wr_n;
    endfunction

    function automatic logic wants_read(input port_cmd_t p);
        return !p.sel_n && p.wr_n;
    endfunction

endpackage

// File: rtl/sst_scan_chain.sv
module sst_scan_chain
    import sst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] rd0,
    input  logic [DATA_W-1:0] rd1,
    output frame_t            frame,
    output logic              ser_out
);

    frame_t sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture) begin
            sr.p0.data <= rd0;
            sr.p1.data <= rd1;
        end else if (shift_en) begin
            sr <= frame_t'({sr[FRAME_W-2:0], ser_in});
        end
    end

    assign frame   = sr;
    assign ser_out = sr[FRAME_W-1];

    // R2: new bit enters at the bottom, the rest moves up one place
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !capture) |=> (sr[0] == $past(ser_in)) &&
                                   (ser_out == $past(sr[FRAME_W-2])));

    // R6: capture leaves the control and address fields alone
    p_capture_ctrl_r6: assert property (@(posedge clk) disable iff (rst)
        capture |=> (sr.bank == $past(sr.bank)) &&
                    (sr.p0.addr == $past(sr.p0.addr)) &&
                    (sr.p1.addr == $past(sr.p1.addr)) &&
                    (sr.p0.mask == $past(sr.p0.mask)) &&
                    (sr.p1.sel_n == $past(sr.p1.sel_n)));

endmodule

// File: rtl/sst_bank.sv
module sst_bank
    import sst_pkg::*;
#(
    parameter int AW = 4,
    parameter int NP = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NP-1:0]                wr,
    input  logic [NP-1:0][AW-1:0]        addr,
    input  logic [NP-1:0][DATA_W-1:0]    wdata,
    input  logic [NP-1:0][MASK_W-1:0]    mask,
    output logic [NP-1:0][DATA_W-1:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Higher-numbered ports are applied later, so they win a shared byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            for (int p = 0; p < NP; p++)
                for (int l = 0; l < MASK_W; l++)
                    if (wr[p] && mask[p][l])
                        mem[addr[p]][8*l +: 8] <= wdata[p][8*l +: 8];
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_rd
        assign rdata[p] = mem[addr[p]];
    end

    // R10: no write means the word under port 0 keeps its value
    p_no_write_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr == '0) |=> (rdata[0] == $past(rdata[0])) || (addr[0] != $past(addr[0])));

    // R5: a port-0-only write with an empty mask changes nothing
    p_mask_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ((wr == NP'(1)) && (mask[0] == '0)) |=>
            (rdata[0] == $past(rdata[0])) || (addr[0] != $past(addr[0])));

endmodule

// File: rtl/sst_bank_array.sv
module sst_bank_array
    import sst_pkg::*;
#(
    parameter int AW          = 4,
    parameter int N_DUAL      = 5,
    parameter int SINGLE_BASE = 8,
    parameter int N_SINGLE    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  frame_t            cmd,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1
);

    localparam int NB = N_DUAL + N_SINGLE;
    localparam int IW = $clog2(NB);

    bank_kind_t        kind;
    logic [IW-1:0]     slot;
    logic              ok0, ok1;
    logic              wr0_req, wr1_req, rd0_req, rd1_req;
    logic [NB-1:0]     bank_hit;
    logic [DATA_W-1:0] q0_all [NB];
    logic [DATA_W-1:0] q1_all [NB];
    logic [DATA_W-1:0] q0_sel, q1_sel;

    always_comb begin
        kind = classify(cmd.bank, N_DUAL, SINGLE_BASE, N_SINGLE);
        if (kind == KIND_SINGLE)
            slot = IW'(N_DUAL + int'(cmd.bank) - SINGLE_BASE);
        else
            slot = IW'(int'(cmd.bank));
    end

    // An address reaching past the bank depth disables that port.
    assign ok0 = (cmd.p0.addr[ADDR_W-1:AW] == '0);
    assign ok1 = (cmd.p1.addr[ADDR_W-1:AW] == '0);

    assign wr0_req = wants_write(cmd.p0) && ok0;
    assign rd0_req = wants_read(cmd.p0)  && ok0;
    assign wr1_req = wants_write(cmd.p1) && ok1 && (kind == KIND_DUAL);
    assign rd1_req = wants_read(cmd.p1)  && ok1 && (kind == KIND_DUAL);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_hit[b] = launch && (kind != KIND_NONE) && (slot == IW'(b));

        if (b < N_DUAL) begin : g_dual
            logic [1:0][DATA_W-1:0] q;
            sst_bank #(.AW(AW), .NP(2)) u_bank (
                .clk   (clk),
                .rst   (rst),
                .wr    ({bank_hit[b] && wr1_req, bank_hit[b] && wr0_req}),
                .addr  ({cmd.p1.addr[AW-1:0], cmd.p0.addr[AW-1:0]}),
                .wdata ({cmd.p1.data, cmd.p0.data}),
                .mask  ({cmd.p1.mask, cmd.p0.mask}),
                .rdata (q)
            );
            assign q0_all[b] = q[0];
            assign q1_all[b] = q[1];
        end else begin : g_single
            logic [0:0][DATA_W-1:0] q;
            sst_bank #(.AW(AW), .NP(1)) u_bank (
                .clk   (clk),
                .rst   (rst),
                .wr    (bank_hit[b] && wr0_req),
                .addr  (cmd.p0.addr[AW-1:0]),
                .wdata (cmd.p0.data),
                .mask  (cmd.p0.mask),
                .rdata (q)
            );
            assign q0_all[b] = q[0];
            assign q1_all[b] = '0;
        end
    end

    assign q0_sel = q0_all[slot];
    assign q1_sel = q1_all[slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd0 <= '0;
            rd1 <= '0;
        end else if (launch) begin
            rd0 <= (kind != KIND_NONE && rd0_req) ? q0_sel : '0;
            rd1 <= rd1_req ? q1_sel : '0;
        end
    end

    // R8: at most one bank is touched per launch
    p_one_bank_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_hit));

    // R8: a single-port bank never returns port-1 data
    p_single_p1_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (launch && kind == KIND_SINGLE) |=> (rd1 == '0));

    // R9: unmapped bank codes return nothing
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (launch && kind == KIND_NONE) |=> (rd0 == '0) && (rd1 == '0));

    // R12: an out-of-range port-0 address returns zero
    p_addr_range_r12: assert property (@(posedge clk) disable iff (rst)
        (launch && !ok0) |=> (rd0 == '0));

endmodule

// File: rtl/scan_sram_tester.sv
module scan_sram_tester
    import sst_pkg::*;
#(
    parameter int ADDR_BITS    = 4,
    parameter int DUAL_BANKS   = 5,
    parameter int SINGLE_BASE  = 8,
    parameter int SINGLE_BANKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_en,
    input  logic scan_in,
    input  logic launch_n,
    input  logic capture,
    output logic scan_out
);

    frame_t            frame;
    logic [DATA_W-1:0] rd0, rd1;

    sst_scan_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (scan_en),
        .ser_in   (scan_in),
        .capture  (capture),
        .rd0      (rd0),
        .rd1      (rd1),
        .frame    (frame),
        .ser_out  (scan_out)
    );

    sst_bank_array #(
        .AW          (ADDR_BITS),
        .N_DUAL      (DUAL_BANKS),
        .SINGLE_BASE (SINGLE_BASE),
        .N_SINGLE    (SINGLE_BANKS)
    ) u_banks (
        .clk    (clk),
        .rst    (rst),
        .launch (!launch_n),
        .cmd    (frame),
        .rd0    (rd0),
        .rd1    (rd1)
    );

    // R1: the serial output is always a defined level after reset
    p_out_known_r1: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(scan_out));

    // R6: a capture edge loads data fields without running the shifter
    p_capture_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (capture && scan_en) |=> (frame.bank == $past(frame.bank)));

endmodule

// File: tb/test_scan_sram_tester.sv
module test_scan_sram_tester;

    localparam int CLK_PERIOD = 25;
    localparam int HALF_LO    = CLK_PERIOD / 2;
    localparam int HALF_HI    = CLK_PERIOD - HALF_LO;

    logic clk = 1'b0;
    logic rst, scan_en, scan_in, launch_n, capture;
    logic scan_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    scan_sram_tester i_scan_sram_tester (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .launch_n (launch_n),
        .capture  (capture),
        .scan_out (scan_out)
    );

    always begin
        #HALF_LO clk = 1'b1;
        #HALF_HI clk = 1'b0;
    end

    task automatic chk(input string req, input logic [111:0] got, input logic [111:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // R3 layout
    function automatic logic [111:0] mk(input logic [3:0] b,
        input logic [15:0] a0, input logic [31:0] d0, input logic s0, input logic w0, input logic [3:0] m0,
        input logic [15:0] a1, input logic [31:0] d1, input logic s1, input logic w1, input logic [3:0] m1);
        return {b, a0, d0, s0, w0, m0, a1, d1, s1, w1, m1};
    endfunction

    function automatic logic [111:0] rd_frame(input logic [3:0] b,
        input logic [15:0] a0, input bit en0, input logic [15:0] a1, input bit en1);
        return mk(b, a0, 32'hC0DE_0000, !en0, 1'b1, 4'hF, a1, 32'hC0DE_1111, !en1, 1'b1, 4'hF);
    endfunction

    function automatic logic [111:0] wr_frame(input logic [3:0] b,
        input logic [15:0] a0, input logic [31:0] d0, input logic [3:0] m0, input bit en0,
        input logic [15:0] a1, input logic [31:0] d1, input logic [3:0] m1, input bit en1);
        return mk(b, a0, d0, !en0, 1'b0, m0, a1, d1, !en1, 1'b0, m1);
    endfunction

    function automatic logic [111:0] with_data(input logic [111:0] f,
        input logic [31:0] d0, input logic [31:0] d1);
        logic [111:0] r;
        r = f;
        r[91:60] = d0;
        r[37:6]  = d1;
        return r;
    endfunction

    task automatic shift_in(input logic [111:0] f);
        for (int i = 0; i < 112; i++) begin
            @(negedge clk);
            scan_en = 1'b1;
            scan_in = f[111-i];
        end
        @(negedge clk);
        scan_en = 1'b0;
        scan_in = 1'b0;
    endtask

    task automatic shift_out(output logic [111:0] r);
        for (int i = 0; i < 112; i++) begin
            @(negedge clk);
            r[111-i] = scan_out;
            scan_en  = 1'b1;
            scan_in  = 1'b0;
        end
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    task automatic pulse_launch();
        @(negedge clk);
        launch_n = 1'b0;
        @(negedge clk);
        launch_n = 1'b1;
    endtask

    task automatic pulse_capture(input bit with_shift);
        @(negedge clk);
        capture = 1'b1;
        if (with_shift) begin
            scan_en = 1'b1;
            scan_in = 1'b1;
        end
        @(negedge clk);
        capture = 1'b0;
        scan_en = 1'b0;
        scan_in = 1'b0;
    endtask

    // Shift, launch, capture, shift out, compare the returned frame.
    task automatic exec(input logic [111:0] f, input logic [31:0] e0, input logic [31:0] e1,
                        input string req, input bit prio = 1'b0);
        logic [111:0] got;
        shift_in(f);
        pulse_launch();
        pulse_capture(prio);
        shift_out(got);
        chk(req, got, with_data(f, e0, e1));
    endtask

    task automatic t_reset();
        logic [111:0] got;
        chk("R1 scan_out after reset", {111'b0, scan_out}, '0);
        shift_out(got);
        chk("R1 register after reset", got, '0);
        exec(rd_frame(4'd0, 16'd0, 1, 16'd3, 1), 32'd0, 32'd0, "R1 memory after reset");
    endtask

    task automatic t_shift();
        logic [111:0] a, b, got;
        a = mk(4'h9, 16'h1234, 32'hDEADBEEF, 1'b0, 1'b1, 4'h5, 16'hFEDC, 32'h0BADF00D, 1'b1, 1'b0, 4'hA);
        b = {56{2'b10}};
        shift_in(a);
        shift_out(got);
        chk("R2 shift through pattern A", got, a);
        shift_in(b);
        shift_out(got);
        chk("R2 shift through alternating", got, b);
    endtask

    task automatic t_dual();
        for (int b = 0; b < 5; b++)
            exec(wr_frame(4'(b), 16'd1, 32'h100 + b, 4'hF, 1, 16'd2, 32'h200 + b, 4'hF, 1),
                 32'd0, 32'd0, "R7 write-only results zero");
        for (int b = 0; b < 5; b++)
            exec(rd_frame(4'(b), 16'd1, 1, 16'd2, 1), 32'h100 + b, 32'h200 + b, "R4 R8 dual readback");
    endtask

    task automatic t_mask();
        exec(wr_frame(4'd2, 16'd7, 32'hAABBCCDD, 4'hF, 1, 16'd0, 32'd0, 4'h0, 0), 0, 0, "R5 full write");
        exec(wr_frame(4'd2, 16'd7, 32'h11223344, 4'b0101, 1, 16'd0, 32'd0, 4'h0, 0), 0, 0, "R5 partial write");
        exec(rd_frame(4'd2, 16'd7, 1, 16'd0, 0), 32'hAA22CC44, 32'd0, "R5 lanes 0 and 2");
        exec(wr_frame(4'd2, 16'd7, 32'h55667788, 4'h0, 1, 16'd0, 32'd0, 4'h0, 0), 0, 0, "R5 empty mask write");
        exec(rd_frame(4'd2, 16'd7, 1, 16'd0, 0), 32'hAA22CC44, 32'd0, "R5 empty mask unchanged");
    endtask

    task automatic t_single();
        for (int b = 8; b < 12; b++)
            exec(wr_frame(4'(b), 16'd1, 32'h800 + b, 4'hF, 1, 16'd3, 32'hFFFF_FFFF, 4'hF, 1), 0, 0, "R8 single write");
        for (int b = 8; b < 12; b++)
            exec(rd_frame(4'(b), 16'd1, 1, 16'd1, 1), 32'h800 + b, 32'd0, "R8 single port1 ignored");
        exec(rd_frame(4'd9, 16'd3, 1, 16'd0, 0), 32'd0, 32'd0, "R8 single port1 write ignored");
        exec(rd_frame(4'd0, 16'd1, 1, 16'd2, 1), 32'h100, 32'h200, "R8 banks independent");
    endtask

    task automatic t_invalid();
        logic [3:0] codes [4];
        codes = '{4'd5, 4'd7, 4'd12, 4'd15};
        foreach (codes[k]) begin
            exec(wr_frame(codes[k], 16'd1, 32'hBAD, 4'hF, 1, 16'd2, 32'hBAD1, 4'hF, 1), 0, 0, "R9 unmapped write");
            exec(rd_frame(codes[k], 16'd1, 1, 16'd2, 1), 32'd0, 32'd0, "R9 unmapped read zero");
        end
        exec(rd_frame(4'd4, 16'd1, 1, 16'd2, 1), 32'h104, 32'h204, "R9 bank 4 untouched");
        exec(rd_frame(4'd11, 16'd1, 1, 16'd0, 0), 32'h80B, 32'd0, "R9 bank 11 untouched");
    endtask

    task automatic t_no_launch();
        shift_in(wr_frame(4'd0, 16'd1, 32'h999, 4'hF, 1, 16'd2, 32'h999, 4'hF, 1));
        exec(rd_frame(4'd0, 16'd1, 1, 16'd2, 1), 32'h100, 32'h200, "R10 shift without launch");
        exec(mk(4'd0, 16'd1, 32'h777, 1'b1, 1'b0, 4'hF, 16'd2, 32'h777, 1'b1, 1'b0, 4'hF),
             0, 0, "R4 idle ports return zero");
        exec(rd_frame(4'd0, 16'd1, 1, 16'd2, 1), 32'h100, 32'h200, "R4 idle ports no write");
    endtask

    task automatic t_capture_priority();
        exec(rd_frame(4'd1, 16'd1, 1, 16'd2, 1), 32'h101, 32'h201, "R6 capture over shift", 1'b1);
    endtask

    task automatic t_same_edge();
        exec(mk(4'd3, 16'd5, 32'h0, 1'b0, 1'b1, 4'hF, 16'd5, 32'h5555, 1'b0, 1'b0, 4'hF),
             32'd0, 32'd0, "R11 read sees old word");
        exec(rd_frame(4'd3, 16'd5, 1, 16'd0, 0), 32'h5555, 32'd0, "R11 write landed");
        exec(wr_frame(4'd3, 16'd6, 32'h11111111, 4'hF, 1, 16'd6, 32'h22222222, 4'hF, 1), 0, 0, "R11 dual write");
        exec(rd_frame(4'd3, 16'd6, 1, 16'd0, 0), 32'h22222222, 32'd0, "R11 port1 wins");
        exec(wr_frame(4'd3, 16'd9, 32'hAAAAAAAA, 4'hF, 1, 16'd9, 32'hBBBBBBBB, 4'b0011, 1), 0, 0, "R11 lane split write");
        exec(rd_frame(4'd3, 16'd0, 0, 16'd9, 1), 32'd0, 32'hAAAABBBB, "R11 per-lane precedence");
    endtask

    task automatic t_addr_range();
        exec(wr_frame(4'd0, 16'h0011, 32'h777, 4'hF, 1, 16'h0000, 32'd0, 4'h0, 0), 0, 0, "R12 high address write");
        exec(rd_frame(4'd0, 16'h0001, 1, 16'h0000, 0), 32'h100, 32'd0, "R12 alias untouched");
        exec(rd_frame(4'd0, 16'h0011, 1, 16'h8002, 1), 32'd0, 32'd0, "R12 high address reads zero");
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

    initial begin
        rst = 1'b1; scan_en = 1'b0; scan_in = 1'b0; launch_n = 1'b1; capture = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shift();
        t_dual();
        t_mask();
        t_single();
        t_invalid();
        t_no_launch();
        t_capture_priority();
        t_same_edge();
        t_addr_range();
        finish_up();
    end

endmodule